// File: doc/BRIEF.md
# Dual-Master Bus Ownership Sequencer

This block sits on the controller side of a two-master selector device that lets either of two hosts drive a shared downstream bus. On an acquire pulse it reads the selector's control byte and its interrupt status byte, and from them it works out whether the downstream bus is powered and which master holds it. It then writes whatever control value moves ownership toward this master. It repeats this after a wait until it owns a powered bus, reports a timeout, or sees an access error. On a release pulse it switches the bus off, but only if this master holds it.

Each of the two ownership-like conditions is coded as a pair of bits. The pair means "off" (for the bus-on pair) or "ours" (for the ownership pair) when its two bits are equal. The value written when taking the bus comes from a fixed sixteen-entry lookup on the control byte's low nibble. Two deadlines start together when an acquire is accepted. Past the first (force) deadline the block stops deferring to the other master and takes the bus, resetting it if needed. Past the second (give-up) deadline, checked after each retry wait, it stops and flags a timeout. All deadlines and waits are parameters counted in clock cycles.

The register port is a valid/ready request channel. Once the block raises `reg_valid`, it holds `reg_valid`, `reg_write`, `reg_addr` and `reg_wdata` unchanged until it samples `reg_ready` high on a rising edge. That edge completes the access. `reg_rdata` and `reg_err` are taken on that same edge. The responder may stall for any number of cycles.

Top module: `bus_owner_seq`

## Requirements
- R1: Control is read and written at address 0x01, status is read at address 0x02, and no other address is used.
- R2: If control shows the bus off (bit2 equal to bit3) and status bit7 is clear, the block writes LUT[ctl[3:0]] | 0x80 and retries after the short wait. LUT is 4,0,1,5,4,4,5,5,0,0,1,1,0,4,5,1.
- R3: If the bus is off and status bit7 is set before the force deadline, the block writes nothing and reads control again only after twice the long wait.
- R4: If the bus is on and owned (bit0 equal to bit1), the block writes ctl & 0x6F when bit7 or bit4 is set, otherwise it writes nothing, and then pulses `acq_done`.
- R5: If the bus is on and owned by the other master before the force deadline, the block writes ctl | 0x80 only when bit7 is clear, then retries after the long wait.
- R6: Once the force deadline has passed, a bus owned by the other master gets LUT[nibble] | 0x90, and an off bus gets LUT[nibble] | 0x80 even when the other master has asked.
- R7: After a retry wait, if the give-up deadline has passed, the block pulses `acq_timeout` and returns to idle without `acq_done`.
- R8: On release, the block reads control. Only when the bus is on and owned does it write (ctl & 0x08) >> 1. In every case it ends with a `rel_done` pulse.
- R9: An access that completes with `reg_err` high ends the sequence at once with an `acc_error` pulse and a return to idle.
- R10: `acq_req` and `rel_req` that arrive while `busy` is high are ignored.
- R11: While `reg_valid` is high and `reg_ready` is low, the request and its fields stay stable.
- R12: After reset the block is idle, with `busy`, `reg_valid` and all outcome pulses low. At most one outcome pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_req | input | 1 | Pulse: start acquiring the bus |
| rel_req | input | 1 | Pulse: start releasing the bus |
| busy | output | 1 | A sequence is in progress |
| acq_done | output | 1 | Pulse: bus acquired |
| acq_timeout | output | 1 | Pulse: give-up deadline passed |
| acc_error | output | 1 | Pulse: register access returned an error |
| rel_done | output | 1 | Pulse: release sequence finished |
| reg_valid | output | 1 | Register access request valid |
| reg_ready | input | 1 | Responder accepts and completes the access |
| reg_write | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Selector register address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid with reg_ready |
| reg_err | input | 1 | Access error, valid with reg_ready |

## Verification
The bench models the selector with a stalling responder and targets these corner cases:
- A peer that keeps asking for a powered-off bus. A design that ignored the status byte would write at once; one that skipped the force deadline would never take the bus.
- A bus held by the other master. A design that did not test bit7 before the read-modify-write would repeat the claim write on every retry. A design that forgot the forced write would never win.
- A locked control register. A design that checked the give-up deadline in the wrong place, or not at all, would hang or stop too early.
- Error responses, and requests made while busy. Here a faulty design would carry on, or would start a second sequence.

// File: rtl/bos_pkg.sv
package bos_pkg;
  localparam logic [7:0] ADDR_CTL  = 8'h01;
  localparam logic [7:0] ADDR_STAT = 8'h02;

  // Control byte bit positions (device-defined)
  localparam int OWN_A  = 0;
  localparam int OWN_B  = 1;
  localparam int PWR_A  = 2;
  localparam int PWR_B  = 3;
  localparam int RST_B  = 4;
  localparam int CLAIM  = 7;
  // Status byte: peer has asked for ownership
  localparam int PEER_ASK = 7;

  localparam logic [7:0] M_CLAIM = 8'h80;
  localparam logic [7:0] M_RESET = 8'h10;

  typedef enum logic [2:0] {S_IDLE, S_RD_CTL, S_RD_STAT, S_WR, S_WAIT} seq_st_t;
  typedef enum logic [1:0] {NX_RETRY, NX_ACQ, NX_REL} after_wr_t;

  function automatic logic bus_off(input logic [7:0] c);
    return c[PWR_A] == c[PWR_B];
  endfunction

  function automatic logic owned(input logic [7:0] c);
    return c[OWN_A] == c[OWN_B];
  endfunction

  function automatic logic [7:0] take_val(input logic [3:0] n);
    logic [2:0] v;
    case (n)
      4'd0, 4'd4, 4'd5, 4'd13:           v = 3'd4;
      4'd1, 4'd8, 4'd9, 4'd12:           v = 3'd0;
      4'd2, 4'd10, 4'd11, 4'd15:         v = 3'd1;
      default:                           v = 3'd5;
    endcase
    return {5'b0, v};
  endfunction
endpackage

// File: rtl/bos_deadline.sv
module bos_deadline #(
  parameter int unsigned FORCE_CYC  = 12_500_000,
  parameter int unsigned GIVEUP_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic force_due,
  output logic giveup_due
);
  localparam int W = $clog2(GIVEUP_CYC + 1);
  localparam logic [W-1:0] LIM_F = W'(FORCE_CYC);
  localparam logic [W-1:0] LIM_G = W'(GIVEUP_CYC);

  logic [W-1:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                elapsed <= '0;
    else if (start)            elapsed <= '0;
    else if (elapsed != LIM_G) elapsed <= elapsed + 1'b1;
  end

  assign force_due  = elapsed >= LIM_F;
  assign giveup_due = elapsed >= LIM_G;

  // R7: once the give-up point is reached it stays reached until a new start
  a_r7_giveup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    giveup_due && !start |=> giveup_due);
endmodule

// File: rtl/bos_wait.sv
module bos_wait #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= len;
    else if (cnt != 0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/bus_owner_seq.sv
module bus_owner_seq
  import bos_pkg::*;
#(
  parameter int unsigned FORCE_CYC  = 12_500_000,
  parameter int unsigned GIVEUP_CYC = 25_000_000,
  parameter int unsigned SHORT_CYC  = 5_000,
  parameter int unsigned LONG_CYC   = 100_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acq_req,
  input  logic       rel_req,
  output logic       busy,
  output logic       acq_done,
  output logic       acq_timeout,
  output logic       acc_error,
  output logic       rel_done,
  output logic       reg_valid,
  input  logic       reg_ready,
  output logic       reg_write,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata,
  input  logic       reg_err
);
  localparam int WT_W = $clog2(2 * LONG_CYC + 1);
  localparam logic [WT_W-1:0] WT_SHORT = WT_W'(SHORT_CYC);
  localparam logic [WT_W-1:0] WT_LONG  = WT_W'(LONG_CYC);
  localparam logic [WT_W-1:0] WT_LONG2 = WT_W'(2 * LONG_CYC);

  seq_st_t    st;
  after_wr_t  nx;
  logic       rel_mode;
  logic [7:0] ctl_q;
  logic [WT_W-1:0] wait_len;
  logic       wait_load;
  logic       wait_exp, force_due, giveup_due;
  logic       xfer, start_acq;

  assign busy      = (st != S_IDLE);
  assign xfer      = reg_valid && reg_ready;
  assign start_acq = (st == S_IDLE) && acq_req;

  bos_deadline #(.FORCE_CYC(FORCE_CYC), .GIVEUP_CYC(GIVEUP_CYC)) u_dl (
    .clk(clk), .rst_n(rst_n), .start(start_acq),
    .force_due(force_due), .giveup_due(giveup_due));

  bos_wait #(.W(WT_W)) u_wt (
    .clk(clk), .rst_n(rst_n), .load(wait_load), .len(wait_len), .expired(wait_exp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nx <= NX_RETRY; rel_mode <= 1'b0; ctl_q <= '0;
      wait_len <= '0; wait_load <= 1'b0;
      reg_valid <= 1'b0; reg_write <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      acq_done <= 1'b0; acq_timeout <= 1'b0; acc_error <= 1'b0; rel_done <= 1'b0;
    end else begin
      acq_done <= 1'b0; acq_timeout <= 1'b0; acc_error <= 1'b0; rel_done <= 1'b0;
      wait_load <= 1'b0;
      case (st)
        S_IDLE: begin
          if (acq_req || rel_req) begin
            rel_mode  <= !acq_req;
            reg_valid <= 1'b1; reg_write <= 1'b0; reg_addr <= ADDR_CTL;
            st        <= S_RD_CTL;
          end
        end
        S_RD_CTL: if (xfer) begin
          reg_valid <= 1'b0;
          ctl_q     <= reg_rdata;
          if (reg_err) begin
            acc_error <= 1'b1; st <= S_IDLE;
          end else if (rel_mode) begin
            if (!bus_off(reg_rdata) && owned(reg_rdata)) begin
              reg_valid <= 1'b1; reg_write <= 1'b1; reg_addr <= ADDR_CTL;
              reg_wdata <= {5'b0, reg_rdata[PWR_B], 2'b0};
              nx <= NX_REL; st <= S_WR;
            end else begin
              rel_done <= 1'b1; st <= S_IDLE;
            end
          end else if (bus_off(reg_rdata)) begin
            reg_valid <= 1'b1; reg_write <= 1'b0; reg_addr <= ADDR_STAT;
            st <= S_RD_STAT;
          end else if (owned(reg_rdata)) begin
            if (reg_rdata[CLAIM] || reg_rdata[RST_B]) begin
              reg_valid <= 1'b1; reg_write <= 1'b1; reg_addr <= ADDR_CTL;
              reg_wdata <= reg_rdata & ~(M_CLAIM | M_RESET);
              nx <= NX_ACQ; st <= S_WR;
            end else begin
              acq_done <= 1'b1; st <= S_IDLE;
            end
          end else begin
            wait_len <= WT_LONG;
            if (force_due) begin
              reg_valid <= 1'b1; reg_write <= 1'b1; reg_addr <= ADDR_CTL;
              reg_wdata <= take_val(reg_rdata[3:0]) | M_CLAIM | M_RESET;
              nx <= NX_RETRY; st <= S_WR;
            end else if (!reg_rdata[CLAIM]) begin
              reg_valid <= 1'b1; reg_write <= 1'b1; reg_addr <= ADDR_CTL;
              reg_wdata <= reg_rdata | M_CLAIM;
              nx <= NX_RETRY; st <= S_WR;
            end else begin
              wait_load <= 1'b1; st <= S_WAIT;
            end
          end
        end
        S_RD_STAT: if (xfer) begin
          reg_valid <= 1'b0;
          if (reg_err) begin
            acc_error <= 1'b1; st <= S_IDLE;
          end else if (!reg_rdata[PEER_ASK] || force_due) begin
            wait_len  <= WT_SHORT;
            reg_valid <= 1'b1; reg_write <= 1'b1; reg_addr <= ADDR_CTL;
            reg_wdata <= take_val(ctl_q[3:0]) | M_CLAIM;
            nx <= NX_RETRY; st <= S_WR;
          end else begin
            wait_len <= WT_LONG2; wait_load <= 1'b1; st <= S_WAIT;
          end
        end
        S_WR: if (xfer) begin
          reg_valid <= 1'b0;
          if (reg_err) begin
            acc_error <= 1'b1; st <= S_IDLE;
          end else begin
            case (nx)
              NX_ACQ:  begin acq_done <= 1'b1; st <= S_IDLE; end
              NX_REL:  begin rel_done <= 1'b1; st <= S_IDLE; end
              default: begin wait_load <= 1'b1; st <= S_WAIT; end
            endcase
          end
        end
        S_WAIT: if (!wait_load && wait_exp) begin
          if (giveup_due) begin
            acq_timeout <= 1'b1; st <= S_IDLE;
          end else begin
            reg_valid <= 1'b1; reg_write <= 1'b0; reg_addr <= ADDR_CTL;
            st <= S_RD_CTL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11: request held stable until accepted
  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready |=> reg_valid && $stable(reg_addr) && $stable(reg_write) && $stable(reg_wdata));
  // R1: only the two register addresses, writes only to control
  a_r1_addr: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> (reg_addr == ADDR_CTL) || (!reg_write && reg_addr == ADDR_STAT));
  // R9: error response aborts at once
  a_r9_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && reg_err |=> acc_error && !busy);
  // R7: timeout only after the give-up deadline
  a_r7_timeout_late: assert property (@(posedge clk) disable iff (!rst_n)
    acq_timeout |-> giveup_due);
  // R12: outcome pulses exclusive
  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acq_done, acq_timeout, acc_error, rel_done}));
endmodule

// File: tb/bus_owner_seq_test.sv
`timescale 1ns/1ps
module bus_owner_seq_test;
  localparam int FT = 600, GT = 1200, ST = 6, LT = 30;

  logic clk = 0, rst_n = 0, acq_req = 0, rel_req = 0;
  logic busy, acq_done, acq_timeout, acc_error, rel_done;
  logic reg_valid, reg_write, reg_ready, reg_err;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  always #4 clk = ~clk;

  bus_owner_seq #(.FORCE_CYC(FT), .GIVEUP_CYC(GT), .SHORT_CYC(ST), .LONG_CYC(LT)) uut (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req), .busy(busy),
    .acq_done(acq_done), .acq_timeout(acq_timeout), .acc_error(acc_error), .rel_done(rel_done),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err));

  int checks = 0, errors = 0;
  // configuration from tasks
  logic cfg_load = 0, cfg_lock = 0, cfg_err = 0;
  logic [7:0] cfg_ctl = 0, cfg_st = 0;
  // device model and logs
  logic [7:0] m_ctl, m_st; logic m_lock, m_err;
  int dly, cyc = 0, wr_n, rd_ctl_n, rd_st_n, first_wr, first_gap, st_cyc, bad_addr, n86;
  int n_done = 0, n_to = 0, n_err = 0, n_rel = 0;
  logic [7:0] wr0, wr_last;

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (acq_done) n_done <= n_done + 1;
    if (acq_timeout) n_to <= n_to + 1;
    if (acc_error) n_err <= n_err + 1;
    if (rel_done) n_rel <= n_rel + 1;
    if (cfg_load) begin
      m_ctl <= cfg_ctl; m_st <= cfg_st; m_lock <= cfg_lock; m_err <= cfg_err;
      wr_n <= 0; rd_ctl_n <= 0; rd_st_n <= 0; first_wr <= -1; first_gap <= -1;
      st_cyc <= -1; bad_addr <= 0; n86 <= 0; dly <= 0; reg_ready <= 0;
    end else begin
      if (reg_valid && !reg_ready) begin
        if (dly == 2) begin
          dly <= 0; reg_ready <= 1;
          reg_rdata <= (reg_addr == 8'h01) ? m_ctl : m_st;
          reg_err <= m_err;
        end else dly <= dly + 1;
      end else reg_ready <= 0;
      if (reg_valid && reg_ready) begin
        if (reg_err) m_err <= 0;
        if (reg_write) begin
          if (reg_addr != 8'h01) bad_addr <= bad_addr + 1;
          if (wr_n == 0) begin wr0 <= reg_wdata; first_wr <= cyc; end
          wr_last <= reg_wdata; wr_n <= wr_n + 1;
          if (reg_wdata == 8'h86) n86 <= n86 + 1;
          if (!m_lock) m_ctl <= reg_wdata;
        end else if (reg_addr == 8'h01) begin
          rd_ctl_n <= rd_ctl_n + 1;
          if (st_cyc >= 0 && first_gap < 0) first_gap <= cyc - st_cyc;
        end else if (reg_addr == 8'h02) begin
          rd_st_n <= rd_st_n + 1;
          if (st_cyc < 0) st_cyc <= cyc;
        end else bad_addr <= bad_addr + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp); end
  endtask

  task automatic setup(input logic [7:0] c, input logic [7:0] s, input logic lk, input logic er);
    @(negedge clk);
    cfg_ctl = c; cfg_st = s; cfg_lock = lk; cfg_err = er; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic run(input logic acq, output int t0, output int t1);
    @(negedge clk);
    if (acq) acq_req = 1; else rel_req = 1;
    t0 = cyc;
    @(negedge clk); acq_req = 0; rel_req = 0;
    while (busy) @(negedge clk);
    t1 = cyc;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && !reg_valid, "R12 idle after reset", {busy, reg_valid}, 0);
    chk({acq_done, acq_timeout, acc_error, rel_done} == 0, "R12 no outcome after reset",
        {acq_done, acq_timeout, acc_error, rel_done}, 0);
  endtask

  task automatic t_off_free;
    int t0, t1, d0, e0;
    d0 = n_done; e0 = n_rel;
    setup(8'h00, 8'h00, 0, 0); run(1, t0, t1);
    chk(wr0 == 8'h84, "R2 take value on free off bus", wr0, 8'h84);
    chk(first_gap >= 0 && first_gap < LT, "R2 short retry wait", first_gap, ST);
    chk(wr_last == 8'h04 && wr_n == 2, "R4 clear claim bit after gaining", wr_last, 8'h04);
    chk(n_done == d0 + 1, "R4 acq_done pulse", n_done - d0, 1);
    chk(bad_addr == 0 && rd_st_n == 1, "R1 addresses", bad_addr, 0);
  endtask

  task automatic t_owned;
    int t0, t1, d0;
    d0 = n_done;
    setup(8'h04, 8'h00, 0, 0); run(1, t0, t1);
    chk(wr_n == 0 && n_done == d0 + 1, "R4 already owned no write", wr_n, 0);
    d0 = n_done;
    setup(8'h14, 8'h00, 0, 0); run(1, t0, t1);
    chk(wr_n == 1 && wr0 == 8'h04, "R4 clear reset bit", wr0, 8'h04);
    chk(n_done == d0 + 1, "R4 acquired after clear", n_done - d0, 1);
  endtask

  task automatic t_peer_ask;
    int t0, t1, d0;
    d0 = n_done;
    setup(8'h00, 8'h80, 0, 0); run(1, t0, t1);
    chk(first_gap >= 2 * LT, "R3 double long wait when peer asks", first_gap, 2 * LT);
    chk(first_wr - t0 >= FT - 2, "R3 no write before force point", first_wr - t0, FT);
    chk(wr0 == 8'h84, "R6 forced take of off bus", wr0, 8'h84);
    chk(n_done == d0 + 1, "R6 acquired after force", n_done - d0, 1);
  endtask

  task automatic t_other_owns;
    int t0, t1, d0;
    d0 = n_done;
    setup(8'h06, 8'h00, 0, 0); run(1, t0, t1);
    chk(wr0 == 8'h86, "R5 claim bit set by read-modify-write", wr0, 8'h86);
    chk(n86 == 1, "R5 claim written only once", n86, 1);
    chk(wr_n == 4, "R6 forced sequence length", wr_n, 4);
    chk(wr_last == 8'h04 && n_done == d0 + 1, "R6 forced ownership then acquired", wr_last, 8'h04);
  endtask

  task automatic t_timeout;
    int t0, t1, d0, o0;
    d0 = n_done; o0 = n_to;
    setup(8'h06, 8'h00, 1, 0); run(1, t0, t1);
    chk(n_to == o0 + 1, "R7 timeout pulse", n_to - o0, 1);
    chk(n_done == d0, "R7 no acquire on timeout", n_done - d0, 0);
    chk(t1 - t0 >= GT, "R7 timeout not before give-up", t1 - t0, GT);
    chk(wr_last == 8'h95, "R6 forced write with reset bit", wr_last, 8'h95);
  endtask

  task automatic t_error;
    int t0, t1, d0, e0;
    d0 = n_done; e0 = n_err;
    setup(8'h00, 8'h00, 0, 1); run(1, t0, t1);
    chk(n_err == e0 + 1, "R9 error pulse", n_err - e0, 1);
    chk(wr_n == 0 && rd_st_n == 0 && n_done == d0, "R9 abort after error", wr_n + rd_st_n, 0);
  endtask

  task automatic t_release;
    int t0, t1, r0;
    r0 = n_rel;
    setup(8'h08, 8'h00, 0, 0); run(0, t0, t1);
    chk(wr_n == 1 && wr0 == 8'h04, "R8 release writes shifted power bit", wr0, 8'h04);
    setup(8'h00, 8'h00, 0, 0); run(0, t0, t1);
    chk(wr_n == 0, "R8 no write when bus off", wr_n, 0);
    setup(8'h06, 8'h00, 0, 0); run(0, t0, t1);
    chk(wr_n == 0, "R8 no write when other owns", wr_n, 0);
    chk(n_rel == r0 + 3, "R8 rel_done each time", n_rel - r0, 3);
  endtask

  task automatic t_busy_ignore;
    int d0;
    d0 = n_done;
    setup(8'h04, 8'h00, 0, 0);
    @(negedge clk); rel_req = 1;
    @(negedge clk); rel_req = 0; acq_req = 1;
    @(negedge clk); acq_req = 0; rel_req = 1;
    @(negedge clk); rel_req = 0;
    repeat (100) @(negedge clk);
    chk(rd_ctl_n == 1 && n_done == d0, "R10 requests while busy ignored", rd_ctl_n, 1);
    chk(!busy && wr0 == 8'h00 && wr_n == 1, "R10 single release only", wr_n, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_off_free; t_owned; t_peer_ask; t_other_owns;
        t_timeout; t_error; t_release; t_busy_ignore;
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule